// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one memory-operand request into an effective address. A request carries a mode select, a base register value, an index register value, a 16-bit constant and an element-size code. Most modes finish in the cycle the request is accepted. In those modes the address and any base-register update come straight out of a combinational datapath.

The memory-indirect mode works differently. It first reads a pointer from memory at the base value, using a valid/ready read request and a separate response strobe. The returned word then becomes the operand address. A four-state sequencer (idle, pointer request, pointer wait, done) runs this fetch. The block refuses new requests until the sequence has finished.

The post-increment and pre-decrement modes also produce a one-cycle base write-back strobe and the new base value. A register file outside the block captures them.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 0 (register indirect): when a request is accepted, `done_valid` is high in the same cycle and `done_addr` equals `req_base`.
- R2: Mode code 1 (displacement): `done_addr` equals `req_base` plus the 16-bit `req_disp`, sign-extended to 32 bits, modulo 2^32.
- R3: Mode code 2 (indexed): `done_addr` equals `req_base + req_index` modulo 2^32.
- R4: Mode code 3 (absolute): `done_addr` equals the sign-extended `req_disp`.
- R5: Mode code 7 (scaled index): `done_addr` equals the sign-extended `req_disp` plus `req_base` plus `req_index` times d, modulo 2^32. The size code maps to d as follows: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R6: Mode code 5 (post-increment): `done_addr` equals `req_base`, `wb_en` is high, and `wb_value` equals `req_base + d`.
- R7: Mode code 6 (pre-decrement): `wb_en` is high, `wb_value` equals `req_base - d`, and `done_addr` equals that same decremented value.
- R8: `wb_en` is high only in a cycle where a request in mode 5 or mode 6 is accepted. In every other mode and cycle it is low.
- R9: Mode code 4 (memory indirect): `done_valid` stays low in the cycle the request is accepted. From the next cycle, `mem_rd_valid` is high with `mem_rd_addr` equal to the accepted base. It holds both steady until a cycle with `mem_rd_ready` high, then drops.
- R10: In the cycle after `mem_resp_valid` is sampled high, `done_valid` is high for exactly one cycle and `done_addr` equals the `mem_resp_data` that was sampled. In the cycle after that, `req_ready` is high again.
- R11: While an indirect sequence is in progress, `req_ready` is low. Requests in that time are ignored: they raise neither `done_valid` nor `wb_en`.
- R12: After a synchronous active-high reset, `req_ready` is high and `done_valid`, `wb_en` and `mem_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Element-size code (d = 1 << code) |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_disp | input | 16 | Signed constant / absolute address |
| done_valid | output | 1 | Effective address valid |
| done_addr | output | 32 | Effective address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_value | output | 32 | New base value |
| mem_rd_valid | output | 1 | Pointer read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_resp_valid | input | 1 | Pointer read data valid |
| mem_resp_data | input | 32 | Pointer read data |

## Verification
The bench sweeps every single-cycle mode against all four size codes. The operands are chosen so that any mistake shows up in the address or the write-back value:
- negative constants, which expose zero-extension instead of sign-extension;
- bases near the top of the address space, which expose a wrong wrap;
- large indices, which expose a scale applied by the wrong power of two or to the wrong operand.

A pre-decrement that reported the old base, or a post-increment that reported the new one, would fail on the address check. A write-back strobe leaking into other modes fails the strobe check.

For the indirect mode, the bench varies the delay before the read request is accepted and the delay before the response arrives. It checks three things:
- the request stays stable while it is stalled;
- the result comes one cycle after the response and lasts one cycle;
- requests sent while the block is busy raise no strobe.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        MODE_REG_IND  = 3'd0,
        MODE_DISP     = 3'd1,
        MODE_INDEXED  = 3'd2,
        MODE_ABS      = 3'd3,
        MODE_MEM_IND  = 3'd4,
        MODE_POST_INC = 3'd5,
        MODE_PRE_DEC  = 3'd6,
        MODE_SCALED   = 3'd7
    } eag_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_PTR_REQ  = 2'd1,
        SEQ_PTR_WAIT = 2'd2,
        SEQ_DONE     = 2'd3
    } eag_seq_e;

    // Per-mode control word steering the address datapath.
    typedef struct packed {
        logic add_base;     // base participates in the sum
        logic add_disp;     // sign-extended constant participates
        logic add_index;    // index participates
        logic scale_index;  // index is shifted by the size code
        logic addr_is_wb;   // address is the updated base value
        logic does_wb;      // base write-back side effect
        logic wb_subtract;  // update is base - d instead of base + d
        logic indirect;     // two-step pointer fetch
    } eag_ctl_t;

    function automatic eag_ctl_t decode_mode(input logic [2:0] mode);
        eag_ctl_t c;
        c = '0;
        case (eag_mode_e'(mode))
            MODE_REG_IND:  c.add_base = 1'b1;
            MODE_DISP:     begin c.add_base = 1'b1; c.add_disp = 1'b1; end
            MODE_INDEXED:  begin c.add_base = 1'b1; c.add_index = 1'b1; end
            MODE_ABS:      c.add_disp = 1'b1;
            MODE_MEM_IND:  begin c.add_base = 1'b1; c.indirect = 1'b1; end
            MODE_POST_INC: begin c.add_base = 1'b1; c.does_wb = 1'b1; end
            MODE_PRE_DEC:  begin
                c.addr_is_wb  = 1'b1;
                c.does_wb     = 1'b1;
                c.wb_subtract = 1'b1;
            end
            MODE_SCALED:   begin
                c.add_base    = 1'b1;
                c.add_disp    = 1'b1;
                c.add_index   = 1'b1;
                c.scale_index = 1'b1;
            end
            default:       c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 16
) (
    input  eag_ctl_t          ctl,
    input  logic [1:0]        size_code,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     index,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     addr,
    output logic [AW-1:0]     new_base
);
    localparam int EXT_W = AW - DISP_W;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] step;
    logic [AW-1:0] index_term;
    logic [AW-1:0] base_term;
    logic [AW-1:0] disp_term;

    generate
        if (EXT_W > 0) begin : g_sext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate

    // d = 1 << size_code; the scale is a shifter, not a multiplier
    assign step = AW'(1) << size_code;

    always_comb begin
        index_term = '0;
        if (ctl.add_index)
            index_term = ctl.scale_index ? (index << size_code) : index;
        base_term = ctl.add_base ? base : '0;
        disp_term = ctl.add_disp ? disp_ext : '0;
    end

    always_comb begin
        new_base = ctl.wb_subtract ? (base - step) : (base + step);
        if (ctl.addr_is_wb)
            addr = new_base;
        else
            addr = base_term + disp_term + index_term;
    end

endmodule

// File: rtl/eag_ind_fsm.sv
module eag_ind_fsm
    import eag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] ptr_addr,
    output logic          idle,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic          mem_resp_valid,
    input  logic [AW-1:0] mem_resp_data,
    output logic          ind_done,
    output logic [AW-1:0] ind_addr
);
    eag_seq_e      state, state_nx;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] data_q;

    always_comb begin
        state_nx = state;
        case (state)
            SEQ_IDLE:     if (start)          state_nx = SEQ_PTR_REQ;
            SEQ_PTR_REQ:  if (mem_rd_ready)   state_nx = SEQ_PTR_WAIT;
            SEQ_PTR_WAIT: if (mem_resp_valid) state_nx = SEQ_DONE;
            SEQ_DONE:                         state_nx = SEQ_IDLE;
            default:                          state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (state == SEQ_IDLE && start)
                ptr_q <= ptr_addr;
            if (state == SEQ_PTR_WAIT && mem_resp_valid)
                data_q <= mem_resp_data;
        end
    end

    assign idle         = (state == SEQ_IDLE);
    assign mem_rd_valid = (state == SEQ_PTR_REQ);
    assign mem_rd_addr  = ptr_q;
    assign ind_done     = (state == SEQ_DONE);
    assign ind_addr     = data_q;

    // R9: a stalled read request keeps its address until accepted
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R10: the indirect result lasts one cycle, then the block is idle
    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        ind_done |=> (idle && !ind_done));

    // R10: the result follows a sampled response
    assert_done_after_resp_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(ind_done) |-> $past(mem_resp_valid));

endmodule

// File: rtl/eag_out_sel.sv
module eag_out_sel
    import eag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          req_valid,
    input  logic          idle,
    input  eag_ctl_t      ctl,
    input  logic [AW-1:0] calc_addr,
    input  logic [AW-1:0] calc_new_base,
    input  logic          ind_done,
    input  logic [AW-1:0] ind_addr,
    output logic          ind_start,
    output logic          done_valid,
    output logic [AW-1:0] done_addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_value
);
    logic accept;

    assign accept     = req_valid && idle;
    assign ind_start  = accept && ctl.indirect;
    assign done_valid = ind_done || (accept && !ctl.indirect);
    assign done_addr  = ind_done ? ind_addr : calc_addr;
    assign wb_en      = accept && ctl.does_wb;
    assign wb_value   = calc_new_base;

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_mode,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_base,
    input  logic [AW-1:0]     req_index,
    input  logic [DISP_W-1:0] req_disp,
    output logic              done_valid,
    output logic [AW-1:0]     done_addr,
    output logic              wb_en,
    output logic [AW-1:0]     wb_value,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_resp_valid,
    input  logic [AW-1:0]     mem_resp_data
);
    eag_ctl_t      ctl;
    logic [AW-1:0] calc_addr;
    logic [AW-1:0] calc_new_base;
    logic          idle;
    logic          ind_start;
    logic          ind_done;
    logic [AW-1:0] ind_addr;

    assign ctl = decode_mode(req_mode);

    eag_addr_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
        .ctl       (ctl),
        .size_code (req_size),
        .base      (req_base),
        .index     (req_index),
        .disp      (req_disp),
        .addr      (calc_addr),
        .new_base  (calc_new_base)
    );

    eag_ind_fsm #(.AW(AW)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .start          (ind_start),
        .ptr_addr       (calc_addr),
        .idle           (idle),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_ready   (mem_rd_ready),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .ind_done       (ind_done),
        .ind_addr       (ind_addr)
    );

    eag_out_sel #(.AW(AW)) u_sel (
        .req_valid     (req_valid),
        .idle          (idle),
        .ctl           (ctl),
        .calc_addr     (calc_addr),
        .calc_new_base (calc_new_base),
        .ind_done      (ind_done),
        .ind_addr      (ind_addr),
        .ind_start     (ind_start),
        .done_valid    (done_valid),
        .done_addr     (done_addr),
        .wb_en         (wb_en),
        .wb_value      (wb_value)
    );

    assign req_ready = idle;

    // R8: the write-back strobe only accompanies the two stepping modes
    assert_wb_only_step_modes_R8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (req_valid && (req_mode == 3'd5 || req_mode == 3'd6)));

    // R11: nothing completes or writes back while a pointer read is pending
    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (!done_valid && !wb_en && !req_ready));

    // R9: an accepted indirect request issues the pointer read next cycle
    assert_ind_issue_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mode == 3'd4) |=> (mem_rd_valid && !done_valid));

endmodule

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_mode;
    logic [1:0]  req_size;
    logic [31:0] req_base;
    logic [31:0] req_index;
    logic [15:0] req_disp;
    logic        done_valid;
    logic [31:0] done_addr;
    logic        wb_en;
    logic [31:0] wb_value;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    eff_addr_gen uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_size(req_size), .req_base(req_base),
        .req_index(req_index), .req_disp(req_disp), .done_valid(done_valid),
        .done_addr(done_addr), .wb_en(wb_en), .wb_value(wb_value),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    logic [31:0] bases [4] = '{32'h0000_1000, 32'hFFFF_FFF8, 32'h8000_0000, 32'h0000_0003};
    logic [31:0] idxs  [3] = '{32'h0000_0005, 32'hFFFF_FFFF, 32'h4000_0001};
    logic [15:0] disps [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFC};

    task automatic ind_test(input logic [31:0] b, input logic [31:0] dat,
                            input int rdy_dly, input int rsp_dly);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'd4; req_base = b; req_size = 2'd2;
        #1;
        chk("R9 no done at accept", {31'd0, done_valid}, 32'd0);
        chk("R8 no wb in indirect", {31'd0, wb_en}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R9 read valid", {31'd0, mem_rd_valid}, 32'd1);
        chk("R9 read addr", mem_rd_addr, b);
        chk("R11 not ready", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            #1;
            chk("R9 read held", {31'd0, mem_rd_valid}, 32'd1);
            chk("R9 addr held", mem_rd_addr, b);
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        // busy request: post-increment must be ignored
        req_valid = 1'b1; req_mode = 3'd5; req_base = 32'h10;
        #1;
        chk("R9 read dropped", {31'd0, mem_rd_valid}, 32'd0);
        chk("R11 busy no wb", {31'd0, wb_en}, 32'd0);
        chk("R11 busy no done", {31'd0, done_valid}, 32'd0);
        for (int i = 0; i < rsp_dly; i++) begin
            @(negedge clk);
            #1;
            chk("R11 wait no wb", {31'd0, wb_en}, 32'd0);
            chk("R11 wait no done", {31'd0, done_valid}, 32'd0);
        end
        mem_resp_valid = 1'b1; mem_resp_data = dat;
        @(negedge clk);
        mem_resp_valid = 1'b0; mem_resp_data = 32'hDEAD_BEEF; req_valid = 1'b0;
        #1;
        chk("R10 done valid", {31'd0, done_valid}, 32'd1);
        chk("R10 done addr", done_addr, dat);
        chk("R11 done not ready", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        #1;
        chk("R10 done one cycle", {31'd0, done_valid}, 32'd0);
        chk("R10 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_mode = '0; req_size = '0;
        req_base = '0; req_index = '0; req_disp = '0;
        mem_rd_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 ready", {31'd0, req_ready}, 32'd1);
        chk("R12 done", {31'd0, done_valid}, 32'd0);
        chk("R12 wb", {31'd0, wb_en}, 32'd0);
        chk("R12 rd", {31'd0, mem_rd_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 8; m++) begin
            if (m == 4) continue;
            for (int s = 0; s < 4; s++)
                for (int bi = 0; bi < 4; bi++)
                    for (int ii = 0; ii < 3; ii++)
                        for (int di = 0; di < 4; di++) begin
                            logic [31:0] b, x, dd, exp_a, exp_w;
                            logic        exp_wb;
                            b = bases[bi]; x = idxs[ii]; dd = 32'd1 << s;
                            exp_w = 32'h0; exp_wb = 1'b0;
                            case (m)
                                0: exp_a = b;
                                1: exp_a = b + sx(disps[di]);
                                2: exp_a = b + x;
                                3: exp_a = sx(disps[di]);
                                5: begin exp_a = b; exp_wb = 1'b1; exp_w = b + dd; end
                                6: begin exp_a = b - dd; exp_wb = 1'b1; exp_w = b - dd; end
                                default: exp_a = sx(disps[di]) + b + x * dd;
                            endcase
                            @(negedge clk);
                            req_valid = 1'b1; req_mode = 3'(m); req_size = 2'(s);
                            req_base = b; req_index = x; req_disp = disps[di];
                            #1;
                            chk("R1-style done same cycle", {31'd0, done_valid}, 32'd1);
                            case (m)
                                0: chk("R1 reg-indirect addr", done_addr, exp_a);
                                1: chk("R2 displacement addr", done_addr, exp_a);
                                2: chk("R3 indexed addr", done_addr, exp_a);
                                3: chk("R4 absolute addr", done_addr, exp_a);
                                5: chk("R6 post-inc addr", done_addr, exp_a);
                                6: chk("R7 pre-dec addr", done_addr, exp_a);
                                default: chk("R5 scaled addr", done_addr, exp_a);
                            endcase
                            chk("R8 wb strobe", {31'd0, wb_en}, {31'd0, exp_wb});
                            if (m == 5) chk("R6 wb value", wb_value, exp_w);
                            if (m == 6) chk("R7 wb value", wb_value, exp_w);
                        end
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R8 no wb when idle input", {31'd0, wb_en}, 32'd0);

        ind_test(32'h0000_2000, 32'h1234_5678, 0, 0);
        ind_test(32'hFFFF_FFFC, 32'h8000_0004, 3, 2);
        ind_test(32'h0000_0000, 32'h0000_0000, 1, 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R10: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule